// File: doc/BRIEF.md
# Load-Forwarding Store Buffer

This block sits between the execution pipeline and the memory write path and keeps memory state precise. A store never writes memory directly. It is placed in a small ring of pending entries, each holding an address, a data word and the sequence tag of the store. A load presents its address together with the result of the cache lookup made in the same cycle. The block searches every pending entry in parallel. When an entry matches, the buffered data replaces the cache data, and the youngest matching store supplies the value.

The oldest pending store is offered on a valid/ready write port only once every older instruction has completed. The pipeline reports this through an input carrying the sequence tag of the oldest instruction that has not completed. An exception flush discards every pending store in a single cycle, so memory never receives a store that follows a faulting instruction. When the ring is full, the enqueue side is stalled.

Top module: `precise_store_queue`

## Requirements
- R1: A store is captured at the rising clock edge where `enq_valid` and `enq_ready` are both high. From the following cycle it is visible to load lookups. It does not appear on the memory port until the release condition of R4 holds.
- R2: When no pending entry matches `ld_addr`, `ld_buf_hit` is 0, `ld_hit` equals `ld_cache_hit`, and `ld_data` equals `ld_cache_data` while `ld_cache_hit` is 1.
- R3: When a pending entry matches `ld_addr`, `ld_buf_hit` and `ld_hit` are 1 and `ld_data` is the buffered data, whatever the cache reports.
- R4: The oldest pending entry is offered (`mem_valid` = 1) only when `(oldest_tag - entry_tag) mod 2^TAG_W` has its top bit clear, that is, when the entry's tag is not younger than the oldest incomplete instruction. Otherwise `mem_valid` is 0.
- R5: When several pending entries match a load address, `ld_data` comes from the most recently enqueued of them.
- R6: While `flush` is high, `enq_ready` and `mem_valid` are 0. In the cycle after a flush cycle the buffer is empty: there is no forwarding hit, no memory request, and `enq_ready` is 1.
- R7: Entries leave in enqueue order, one per cycle with `mem_valid` and `mem_ready` both high. `mem_addr`/`mem_data` stay unchanged while the port waits for `mem_ready`. An entry remains searchable until its handshake.
- R8: With DEPTH (default 4) entries pending, `enq_ready` is 0 and a store offered on the enqueue side is dropped. Occupancy never exceeds DEPTH.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Exception flush: discard all pending stores |
| enq_valid | input | 1 | Store offered for buffering |
| enq_ready | output | 1 | Buffer can accept a store this cycle |
| enq_addr | input | ADDR_W | Store address |
| enq_data | input | DATA_W | Store data |
| enq_tag | input | TAG_W | Sequence tag of the store |
| oldest_tag | input | TAG_W | Tag of the oldest incomplete instruction |
| ld_addr | input | ADDR_W | Load address to search |
| ld_cache_hit | input | 1 | Cache reports a hit for the load |
| ld_cache_data | input | DATA_W | Cache data for the load |
| ld_hit | output | 1 | Load data is valid (buffer or cache) |
| ld_buf_hit | output | 1 | Load data came from the buffer |
| ld_data | output | DATA_W | Load result |
| mem_valid | output | 1 | A released store is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered store |
| mem_addr | output | ADDR_W | Address of the offered store |
| mem_data | output | DATA_W | Data of the offered store |

## Verification
The bench loads two stores to the same address so that both match. A lookup that ignored age order would return the older data. It then opens the release window one tag at a time. A design that gated on the wrong tag, or compared tags without wrap, would either offer the younger store early or never offer it.

A held write port checks that the offered store stays stable and is not lost, and a burst of three released stores checks drain order. The bench fills the buffer with stores that are not yet releasable, offers a fifth store, then flushes. A design that overwrote an entry when full would forward the dropped store's data. A flush that left stale entries would forward old data, or issue memory writes afterwards.

// File: rtl/psq_pkg.sv
package psq_pkg;

    // Advance a ring index by an offset, wrapping at the ring depth.
    function automatic int unsigned ring_add(int unsigned base, int unsigned off,
                                             int unsigned depth);
        int unsigned s;
        s = base + off;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/psq_match.sv
module psq_match #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int PW     = 2,
    parameter int CW     = 3
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
    input  logic [PW-1:0]                head,
    input  logic [CW-1:0]                count,
    input  logic [ADDR_W-1:0]            ld_addr,
    output logic                         hit,
    output logic [DATA_W-1:0]            data
);
    import psq_pkg::*;

    // Compare vector in age order: position 0 is the oldest pending entry.
    logic [DEPTH-1:0]   age_match;
    logic [PW-1:0]      age_idx [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_age
        assign age_idx[j]   = PW'(ring_add(32'(head), j, DEPTH));
        assign age_match[j] = (count > CW'(j)) && (slot_addr[age_idx[j]] == ld_addr);
    end

    // Later (younger) positions override earlier ones.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (age_match[j]) begin
                hit  = 1'b1;
                data = slot_data[age_idx[j]];
            end
        end
    end

endmodule

// File: rtl/psq_release.sv
module psq_release #(
    parameter int TAG_W = 8
) (
    input  logic             head_live,
    input  logic [TAG_W-1:0] head_tag,
    input  logic [TAG_W-1:0] oldest_tag,
    input  logic             flush,
    output logic             offer
);
    // Tag distance with wrap: top bit clear means the head is not younger
    // than the oldest incomplete instruction.
    logic [TAG_W-1:0] gap;

    always_comb begin
        gap   = oldest_tag - head_tag;
        offer = head_live && !flush && !gap[TAG_W-1];
    end

endmodule

// File: rtl/precise_store_queue.sv
module precise_store_queue #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [DATA_W-1:0] enq_data,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic [TAG_W-1:0]  oldest_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_cache_hit,
    input  logic [DATA_W-1:0] ld_cache_data,
    output logic              ld_hit,
    output logic              ld_buf_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    import psq_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [PW-1:0]                head;
        logic [PW-1:0]                tail;
        logic [CW-1:0]                count;
    } ring_t;

    ring_t s_d, s_q;

    logic              push, pop;
    logic              buf_hit;
    logic [DATA_W-1:0] buf_data;
    logic [TAG_W-1:0]  head_tag;

    assign head_tag  = s_q.tag[s_q.head];
    assign enq_ready = (s_q.count != CW'(DEPTH)) && !flush;
    assign push      = enq_valid && enq_ready;
    assign pop       = mem_valid && mem_ready;
    assign mem_addr  = s_q.addr[s_q.head];
    assign mem_data  = s_q.data[s_q.head];

    psq_release #(.TAG_W(TAG_W)) u_rel (
        .head_live  (s_q.count != '0),
        .head_tag   (head_tag),
        .oldest_tag (oldest_tag),
        .flush      (flush),
        .offer      (mem_valid)
    );

    psq_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PW     (PW),
        .CW     (CW)
    ) u_match (
        .slot_addr (s_q.addr),
        .slot_data (s_q.data),
        .head      (s_q.head),
        .count     (s_q.count),
        .ld_addr   (ld_addr),
        .hit       (buf_hit),
        .data      (buf_data)
    );

    // Buffered match overrides the cache.
    always_comb begin
        ld_buf_hit = buf_hit;
        ld_hit     = buf_hit || ld_cache_hit;
        if (buf_hit)           ld_data = buf_data;
        else if (ld_cache_hit) ld_data = ld_cache_data;
        else                   ld_data = '0;
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.head  = '0;
            s_d.tail  = '0;
            s_d.count = '0;
        end else begin
            if (push) begin
                s_d.addr[s_q.tail] = enq_addr;
                s_d.data[s_q.tail] = enq_data;
                s_d.tag[s_q.tail]  = enq_tag;
                s_d.tail           = PW'(ring_add(32'(s_q.tail), 1, DEPTH));
            end
            if (pop) begin
                s_d.head = PW'(ring_add(32'(s_q.head), 1, DEPTH));
            end
            case ({push, pop})
                2'b10:   s_d.count = s_q.count + CW'(1);
                2'b01:   s_d.count = s_q.count - CW'(1);
                default: s_d.count = s_q.count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/psq_checker.sv
module psq_checker #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 8,
    parameter int DEPTH  = 4,
    parameter int CW     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              enq_ready,
    input logic              mem_valid,
    input logic              ld_buf_hit,
    input logic              ld_hit,
    input logic              ld_cache_hit,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] ld_cache_data,
    input logic [TAG_W-1:0]  oldest_tag,
    input logic [TAG_W-1:0]  head_tag,
    input logic [CW-1:0]     count
);
    logic [TAG_W-1:0] age_gap;
    assign age_gap = oldest_tag - head_tag;

    p_flush_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!enq_ready && !mem_valid));

    p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!mem_valid && !ld_buf_hit && count == '0));

    p_release_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !age_gap[TAG_W-1]);

    p_buf_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_buf_hit |-> ld_hit);

    p_cache_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_buf_hit && ld_cache_hit) |-> (ld_hit && ld_data == ld_cache_data));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !enq_ready);

endmodule

bind precise_store_queue psq_checker #(
    .DATA_W (DATA_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH),
    .CW     (CW)
) u_psq_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .enq_ready     (enq_ready),
    .mem_valid     (mem_valid),
    .ld_buf_hit    (ld_buf_hit),
    .ld_hit        (ld_hit),
    .ld_cache_hit  (ld_cache_hit),
    .ld_data       (ld_data),
    .ld_cache_data (ld_cache_data),
    .oldest_tag    (oldest_tag),
    .head_tag      (head_tag),
    .count         (s_q.count)
);

// File: tb/precise_store_queue_tb.sv
module precise_store_queue_tb;
    localparam int AW = 16, DW = 16, TW = 4, DEPTH = 4;

    logic          clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic          enq_valid = 1'b0, enq_ready;
    logic [AW-1:0] enq_addr = '0;
    logic [DW-1:0] enq_data = '0;
    logic [TW-1:0] enq_tag = '0, oldest_tag = '0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_cache_hit = 1'b0;
    logic [DW-1:0] ld_cache_data = '0;
    logic          ld_hit, ld_buf_hit, mem_valid, mem_ready = 1'b0;
    logic [DW-1:0] ld_data, mem_data;
    logic [AW-1:0] mem_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    precise_store_queue #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
        .enq_data(enq_data), .enq_tag(enq_tag), .oldest_tag(oldest_tag),
        .ld_addr(ld_addr), .ld_cache_hit(ld_cache_hit), .ld_cache_data(ld_cache_data),
        .ld_hit(ld_hit), .ld_buf_hit(ld_buf_hit), .ld_data(ld_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Move to 2 ns after the next rising edge; inputs change there.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic enq(logic [AW-1:0] a, logic [DW-1:0] d, logic [TW-1:0] t);
        enq_valid = 1'b1; enq_addr = a; enq_data = d; enq_tag = t;
        tick();
        enq_valid = 1'b0;
    endtask

    task automatic load(logic [AW-1:0] a, logic ch, logic [DW-1:0] cd);
        ld_addr = a; ld_cache_hit = ch; ld_cache_data = cd;
        #1;
    endtask

    task automatic t_reset();
        #1;
        chk("R8 ready after reset", 32'(enq_ready), 1);
        chk("R4 no request after reset", 32'(mem_valid), 0);
        load(16'h0000, 1'b0, 16'h0);
        chk("R2 no hit after reset", 32'(ld_hit), 0);
    endtask

    task automatic t_cache_only();
        load(16'h0042, 1'b1, 16'hAAAA);
        chk("R2 cache hit passes", 32'(ld_hit), 1);
        chk("R2 no buffer hit", 32'(ld_buf_hit), 0);
        chk("R2 cache data", 32'(ld_data), 32'hAAAA);
    endtask

    task automatic t_forward();
        oldest_tag = 4'd3;
        enq(16'h0010, 16'h1111, 4'd5);
        #1;
        chk("R1 store held, not released", 32'(mem_valid), 0);
        load(16'h0010, 1'b1, 16'hBEEF);
        chk("R3 buffer hit", 32'(ld_buf_hit), 1);
        chk("R3 buffer overrides cache", 32'(ld_data), 32'h1111);
    endtask

    task automatic t_youngest();
        enq(16'h0010, 16'h2222, 4'd6);
        load(16'h0010, 1'b1, 16'hBEEF);
        chk("R5 youngest match", 32'(ld_data), 32'h2222);
    endtask

    task automatic t_release();
        oldest_tag = 4'd5;
        #1;
        chk("R4 head released", 32'(mem_valid), 1);
        chk("R4 head data", 32'(mem_data), 32'h1111);
        tick();
        chk("R7 held while not ready", 32'(mem_valid), 1);
        chk("R7 stable address", 32'(mem_addr), 32'h0010);
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        #1;
        chk("R4 younger store gated", 32'(mem_valid), 0);
        load(16'h0010, 1'b1, 16'hBEEF);
        chk("R7 remaining store searchable", 32'(ld_data), 32'h2222);
        oldest_tag = 4'd6;
        #1;
        chk("R7 second store in order", 32'(mem_data), 32'h2222);
        chk("R4 second store released", 32'(mem_valid), 1);
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        load(16'h0010, 1'b1, 16'hBEEF);
        chk("R7 drained store gone", 32'(ld_buf_hit), 0);
        chk("R2 cache after drain", 32'(ld_data), 32'hBEEF);
    endtask

    task automatic t_full_flush();
        oldest_tag = 4'd0;
        for (int i = 0; i < DEPTH; i++)
            enq(16'h0100 + 16'(i), 16'h3000 + 16'(i), 4'(8 + i));
        #1;
        chk("R8 stall when full", 32'(enq_ready), 0);
        chk("R4 wrapped tags gated", 32'(mem_valid), 0);
        enq(16'h0077, 16'h7777, 4'd12);
        load(16'h0077, 1'b0, 16'h0);
        chk("R8 dropped store not buffered", 32'(ld_buf_hit), 0);
        load(16'h0101, 1'b0, 16'h0);
        chk("R8 contents intact", 32'(ld_data), 32'h3001);
        oldest_tag = 4'd11;
        flush = 1'b1;
        #1;
        chk("R6 no request during flush", 32'(mem_valid), 0);
        chk("R6 no enqueue during flush", 32'(enq_ready), 0);
        tick();
        flush = 1'b0;
        #1;
        chk("R6 empty after flush", 32'(mem_valid), 0);
        chk("R6 ready after flush", 32'(enq_ready), 1);
        load(16'h0101, 1'b1, 16'h5555);
        chk("R6 no stale forward", 32'(ld_data), 32'h5555);
    endtask

    task automatic t_order();
        oldest_tag = 4'd3;
        mem_ready = 1'b0;
        enq(16'h00A0, 16'h0A0A, 4'd1);
        enq(16'h00A1, 16'h0A1A, 4'd2);
        enq(16'h00A2, 16'h0A2A, 4'd3);
        mem_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R7 drain valid", 32'(mem_valid), 1);
            chk("R7 drain order", 32'(mem_addr), 32'(16'h00A0 + 16'(i)));
            tick();
        end
        #1;
        chk("R7 empty after burst", 32'(mem_valid), 0);
        mem_ready = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_cache_only();
        t_forward();
        t_youngest();
        t_release();
        t_full_flush();
        t_order();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule